// File: doc/BRIEF.md
# Indirect CSR Access Bridge

This block gives a host a narrow window onto a bank of up to 256 internal 32-bit control/status registers. The host does not address the bank directly. It uses two host-visible registers. A command register carries the target index, a direction flag and a go/busy flag. A data register carries the value to store, or receives the value fetched.

Setting the go flag starts one transfer. The request crosses into the internal clock domain with a toggle handshake. There, a bus master issues a single-cycle strobe to the bank and, for a read, captures the returned word. The completion toggles back into the host domain. Busy drops only after that, so the host polls the command register until busy reads low and then collects read data from the data register. While a transfer is in flight, the bridge refuses every host write to the command or data register.

Top module: `csr_bridge_top`

## Requirements
- R1: After reset, the command register (host offset 0xA4) and the data register (host offset 0xA8) both read 0x00000000, and no internal strobe is issued.
- R2: A host write to the command register with bit 31 = 1 while idle sets busy; reading the command register before completion returns bit 31 = 1 together with the written direction (bit 30) and index (bits 7:0).
- R3: With command bit 30 = 0 (store), the access drives int_write = 1, int_addr = command bits 7:0 and int_wdata = the data register contents.
- R4: With command bit 30 = 1 (fetch), the access drives int_write = 0, and once busy reads low the data register holds the word the bank returned for that index.
- R5: Busy clears by itself once the access has completed and its acknowledge has returned to the host domain.
- R6: Command bits 29:8 always read as zero, whatever value was written to them.
- R7: While busy is set, host writes to the command and data registers are ignored: the fields, the data value and the strobe count are unchanged by them.
- R8: A command write with bit 31 = 0 starts no access and cannot abort one in flight; while idle it updates only the readable index and direction fields.
- R9: Host offsets other than 0xA4 and 0xA8 read as zero, and writes to them change no register and start no access.
- R10: Each started access produces exactly one int_strobe pulse, one internal clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host-side clock |
| hrst | input | 1 | Host-side synchronous reset, active high |
| host_addr | input | 8 | Host byte offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; data appears on host_rdata next cycle |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| iclk | input | 1 | Internal register-bank clock |
| irst | input | 1 | Internal-side synchronous reset, active high |
| int_strobe | output | 1 | One-cycle access strobe to the bank |
| int_write | output | 1 | 1 = store, 0 = fetch, valid with int_strobe |
| int_addr | output | 8 | Bank register index |
| int_wdata | output | 32 | Store data |
| int_rdata | input | 32 | Fetch data from the bank, sampled in the strobe cycle |

## Verification
The main path runs through a table of stores and fetches. It mixes the lowest and highest indices, fetches of untouched entries and fetches that follow a store to the same index. This separates a wrong index or direction from stale or misrouted data. Direct cases cover several conditions: fields written into reserved bits, a command with the go flag clear, writes to unmapped offsets, and host writes landed during an in-flight store and an in-flight fetch. Each of these shows whether the freeze and the decode hold. A strobe counter in the bank model tells a missing or doubled access apart from a correct one.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;
  localparam int CMD_GO_BIT = 31;
  localparam int CMD_RD_BIT = 30;
  localparam int IDX_FIELD_W = 8;
  localparam logic [7:0] OFS_CMD  = 8'hA4;
  localparam logic [7:0] OFS_DATA = 8'hA8;

  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_ACCESS = 2'd1,
    M_REPLY  = 2'd2
  } master_state_t;
endpackage

// File: rtl/csr_sync2.sv
module csr_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/csr_host_regs.sv
module csr_host_regs
  import csr_bridge_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              req_tgl_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              acc_read_o,
  output logic [DATA_W-1:0] acc_wdata_o,
  input  logic              ack_tgl_i,
  input  logic [DATA_W-1:0] rcap_i
);
  logic              busy_q, dir_q, req_q, ack_seen_q, ack_s, ack_evt;
  logic [ADDR_W-1:0] idx_q;
  logic [DATA_W-1:0] data_q, rd_mux;
  logic [IDX_FIELD_W-1:0] idx_view;
  logic              wr_cmd, wr_data;

  csr_sync2 #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_tgl_i), .q(ack_s)
  );

  assign ack_evt = ack_s != ack_seen_q;
  assign wr_cmd  = host_wr && (host_addr == OFS_CMD)  && !busy_q;
  assign wr_data = host_wr && (host_addr == OFS_DATA) && !busy_q;

  always_comb begin
    idx_view = '0;
    idx_view[ADDR_W-1:0] = idx_q;
    rd_mux = '0;
    if (host_addr == OFS_CMD) begin
      rd_mux[CMD_GO_BIT] = busy_q;
      rd_mux[CMD_RD_BIT] = dir_q;
      rd_mux[IDX_FIELD_W-1:0] = idx_view;
    end else if (host_addr == OFS_DATA) begin
      rd_mux = data_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      dir_q      <= 1'b0;
      req_q      <= 1'b0;
      ack_seen_q <= 1'b0;
      idx_q      <= '0;
      data_q     <= '0;
      host_rdata <= '0;
    end else begin
      if (ack_evt) begin
        ack_seen_q <= ack_s;
        busy_q     <= 1'b0;
        if (dir_q) data_q <= rcap_i;
      end
      if (wr_cmd) begin
        idx_q <= host_wdata[ADDR_W-1:0];
        dir_q <= host_wdata[CMD_RD_BIT];
        if (host_wdata[CMD_GO_BIT]) begin
          busy_q <= 1'b1;
          req_q  <= ~req_q;
        end
      end
      if (wr_data) data_q <= host_wdata;
      if (host_rd) host_rdata <= rd_mux;
    end
  end

  assign req_tgl_o   = req_q;
  assign acc_addr_o  = idx_q;
  assign acc_read_o  = dir_q;
  assign acc_wdata_o = data_q;

  p_go_sets_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == OFS_CMD && !busy_q && host_wdata[CMD_GO_BIT]) |=> busy_q);

  p_busy_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !ack_evt) |=> (busy_q && $stable(data_q) && $stable(idx_q) && $stable(dir_q) && $stable(req_q)));

  p_zero_go_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == OFS_CMD && !busy_q && !host_wdata[CMD_GO_BIT]) |=> (!busy_q && $stable(req_q)));
endmodule

// File: rtl/csr_int_master.sv
module csr_int_master
  import csr_bridge_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_tgl_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_read_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic              int_strobe,
  output logic              int_write,
  output logic [ADDR_W-1:0] int_addr,
  output logic [DATA_W-1:0] int_wdata,
  input  logic [DATA_W-1:0] int_rdata,
  output logic              ack_tgl_o,
  output logic [DATA_W-1:0] rcap_o
);
  master_state_t state_q;
  logic req_s, req_seen_q, ack_q;
  logic [DATA_W-1:0] rcap_q;

  csr_sync2 #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .d(req_tgl_i), .q(req_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= M_IDLE;
      req_seen_q <= 1'b0;
      ack_q      <= 1'b0;
      rcap_q     <= '0;
      int_strobe <= 1'b0;
      int_write  <= 1'b0;
      int_addr   <= '0;
      int_wdata  <= '0;
    end else begin
      case (state_q)
        M_IDLE: begin
          if (req_s != req_seen_q) begin
            req_seen_q <= req_s;
            int_strobe <= 1'b1;
            int_write  <= !acc_read_i;
            int_addr   <= acc_addr_i;
            int_wdata  <= acc_wdata_i;
            state_q    <= M_ACCESS;
          end
        end
        M_ACCESS: begin
          int_strobe <= 1'b0;
          if (!int_write) rcap_q <= int_rdata;
          state_q <= M_REPLY;
        end
        M_REPLY: begin
          ack_q   <= ~ack_q;
          state_q <= M_IDLE;
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign ack_tgl_o = ack_q;
  assign rcap_o    = rcap_q;

  p_strobe_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    int_strobe |=> !int_strobe);

  p_ack_after_capture_r5: assert property (@(posedge clk) disable iff (rst)
    int_strobe |=> ##1 (ack_tgl_o != $past(ack_tgl_o)));

  p_rcap_held_r4: assert property (@(posedge clk) disable iff (rst)
    (!int_strobe && state_q != M_ACCESS) |=> $stable(rcap_o));
endmodule

// File: rtl/csr_bridge_top.sv
module csr_bridge_top #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              hclk,
  input  logic              hrst,
  input  logic [7:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              iclk,
  input  logic              irst,
  output logic              int_strobe,
  output logic              int_write,
  output logic [ADDR_W-1:0] int_addr,
  output logic [DATA_W-1:0] int_wdata,
  input  logic [DATA_W-1:0] int_rdata
);
  logic              req_tgl, ack_tgl, acc_read;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata, rcap;

  csr_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_host (
    .clk(hclk), .rst(hrst),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .req_tgl_o(req_tgl), .acc_addr_o(acc_addr), .acc_read_o(acc_read),
    .acc_wdata_o(acc_wdata), .ack_tgl_i(ack_tgl), .rcap_i(rcap)
  );

  csr_int_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_master (
    .clk(iclk), .rst(irst),
    .req_tgl_i(req_tgl), .acc_addr_i(acc_addr), .acc_read_i(acc_read),
    .acc_wdata_i(acc_wdata),
    .int_strobe(int_strobe), .int_write(int_write), .int_addr(int_addr),
    .int_wdata(int_wdata), .int_rdata(int_rdata),
    .ack_tgl_o(ack_tgl), .rcap_o(rcap)
  );
endmodule

// File: tb/csr_bridge_top_tb.sv
module csr_bridge_top_tb;
  localparam logic [7:0] A_CMD  = 8'hA4;
  localparam logic [7:0] A_DATA = 8'hA8;
  localparam int NVEC = 8;
  // entry: {fetch, index, store value}
  localparam logic [40:0] VEC [0:NVEC-1] = '{
    {1'b0, 8'h00, 32'hDEAD_0001},
    {1'b1, 8'h00, 32'h0},
    {1'b0, 8'hFF, 32'h1234_5678},
    {1'b1, 8'hFF, 32'h0},
    {1'b1, 8'h3C, 32'h0},
    {1'b0, 8'h3C, 32'hFFFF_FFFF},
    {1'b1, 8'h3C, 32'h0},
    {1'b1, 8'h81, 32'h0}
  };

  logic hclk = 0, iclk = 0, hrst = 1, irst = 1;
  always #2.5 hclk = ~hclk;
  always #3.5 iclk = ~iclk;

  logic [7:0]  host_addr = '0;
  logic        host_wr = 0, host_rd = 0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        int_strobe, int_write;
  logic [7:0]  int_addr;
  logic [31:0] int_wdata, int_rdata;

  csr_bridge_top u_dut (
    .hclk(hclk), .hrst(hrst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .iclk(iclk), .irst(irst), .int_strobe(int_strobe), .int_write(int_write),
    .int_addr(int_addr), .int_wdata(int_wdata), .int_rdata(int_rdata)
  );

  function automatic logic [31:0] seed(int i);
    return {i[7:0], ~i[7:0], i[7:0] ^ 8'h5A, 8'hC3};
  endfunction

  logic [31:0] bank [0:255];
  logic [31:0] refm [0:255];
  int strobes = 0, wide = 0;
  logic prev_strobe = 0;
  logic [7:0] last_addr = '0;
  logic last_write = 0;
  logic [31:0] last_wdata = '0;
  initial for (int i = 0; i < 256; i++) begin bank[i] = seed(i); refm[i] = seed(i); end

  assign int_rdata = bank[int_addr];
  always @(posedge iclk) begin
    prev_strobe <= int_strobe;
    if (int_strobe && prev_strobe) wide++;
    if (int_strobe) begin
      strobes++;
      last_addr  <= int_addr;
      last_write <= int_write;
      last_wdata <= int_wdata;
      if (int_write) bank[int_addr] <= int_wdata;
    end
  end

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always @(posedge hclk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    @(negedge hclk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge hclk); host_wr = 0;
  endtask

  task automatic hr(input logic [7:0] a, output logic [31:0] d);
    @(negedge hclk); host_addr = a; host_rd = 1;
    @(negedge hclk); host_rd = 0; d = host_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int k = 0; k < 500; k++) begin
      hr(A_CMD, v);
      if (!v[31]) begin ok = 1; break; end
    end
  endtask

  initial begin
    logic [31:0] v;
    bit ok;
    int s0;
    repeat (10) @(posedge iclk);
    @(negedge hclk); hrst = 0;
    @(negedge iclk); irst = 0;
    repeat (4) @(negedge hclk);

    // R1 reset state
    hr(A_CMD, v);  chk(v == 0, "R1 cmd reset", v, 0);
    hr(A_DATA, v); chk(v == 0, "R1 data reset", v, 0);
    chk(strobes == 0, "R1 no strobe", strobes, 0);

    // R6 reserved bits, R8 go clear starts nothing
    hw(A_CMD, 32'h3FFF_FF12);
    hr(A_CMD, v); chk(v == 32'h0000_0012, "R6 reserved zero", v, 32'h12);
    hw(A_CMD, 32'h7FFF_FF34);
    repeat (30) @(negedge hclk);
    hr(A_CMD, v); chk(v == 32'h4000_0034, "R8 fields only", v, 32'h4000_0034);
    chk(strobes == 0, "R8 no access", strobes, 0);

    // R9 unmapped offsets
    hw(A_DATA, 32'h0BAD_F00D);
    hw(8'hA0, 32'h8000_0001);
    hw(8'hAC, 32'h1111_1111);
    repeat (30) @(negedge hclk);
    hr(8'hA0, v);  chk(v == 0, "R9 unmapped read", v, 0);
    hr(A_DATA, v); chk(v == 32'h0BAD_F00D, "R9 data untouched", v, 32'h0BAD_F00D);
    hr(A_CMD, v);  chk(v == 32'h4000_0034, "R9 cmd untouched", v, 32'h4000_0034);
    chk(strobes == 0, "R9 no access", strobes, 0);

    // R2 busy visible in flight
    hw(A_DATA, 32'h5555_AAAA);
    s0 = strobes;
    hw(A_CMD, 32'h8000_0042);
    hr(A_CMD, v); chk(v == 32'h8000_0042, "R2 busy set", v, 32'h8000_0042);
    wait_idle(ok); chk(ok, "R5 busy clears", {31'b0, ok}, 1);
    refm[8'h42] = 32'h5555_AAAA;
    chk(bank[8'h42] == 32'h5555_AAAA, "R3 stored", bank[8'h42], 32'h5555_AAAA);
    chk(strobes == s0 + 1, "R10 one strobe", strobes, s0 + 1);

    // table walk: R3 store, R4 fetch, R5, R10
    for (int n = 0; n < NVEC; n++) begin
      logic fetch;
      logic [7:0] idx;
      logic [31:0] val;
      {fetch, idx, val} = VEC[n];
      s0 = strobes;
      if (!fetch) begin
        hw(A_DATA, val);
        hw(A_CMD, {24'h800000, idx});
        wait_idle(ok); chk(ok, "R5 store done", {31'b0, ok}, 1);
        refm[idx] = val;
        chk(last_write == 1, "R3 direction", {31'b0, last_write}, 1);
        chk(last_addr == idx, "R3 index", {24'b0, last_addr}, {24'b0, idx});
        chk(last_wdata == val, "R3 value", last_wdata, val);
      end else begin
        hw(A_CMD, {24'hC00000, idx});
        wait_idle(ok); chk(ok, "R5 fetch done", {31'b0, ok}, 1);
        hr(A_DATA, v); chk(v == refm[idx], "R4 fetch data", v, refm[idx]);
        chk(last_write == 0, "R4 direction", {31'b0, last_write}, 0);
        chk(last_addr == idx, "R4 index", {24'b0, last_addr}, {24'b0, idx});
      end
      chk(strobes == s0 + 1, "R10 one per access", strobes, s0 + 1);
    end

    // R7 writes during in-flight fetch
    s0 = strobes;
    hw(A_CMD, 32'hC000_0077);
    hw(A_DATA, 32'hFEED_FEED);
    hw(A_CMD, 32'h8000_0010);
    hw(A_CMD, 32'h0000_0000);
    wait_idle(ok); chk(ok, "R8 no abort", {31'b0, ok}, 1);
    hr(A_DATA, v); chk(v == refm[8'h77], "R7 fetch data kept", v, refm[8'h77]);
    hr(A_CMD, v);  chk(v == 32'h4000_0077, "R7 cmd kept", v, 32'h4000_0077);
    chk(strobes == s0 + 1, "R7 no extra access", strobes, s0 + 1);

    // R7 writes during in-flight store
    s0 = strobes;
    hw(A_DATA, 32'hA1B2_C3D4);
    hw(A_CMD, 32'h8000_0005);
    hw(A_DATA, 32'h0000_0000);
    wait_idle(ok);
    chk(bank[8'h05] == 32'hA1B2_C3D4, "R7 store value kept", bank[8'h05], 32'hA1B2_C3D4);
    chk(strobes == s0 + 1, "R7 single store", strobes, s0 + 1);
    chk(wide == 0, "R10 strobe width", wide, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule